// File: doc/BRIEF.md
# I2C Write-Only Control Register Slave

This block is a write-only I2C target that lets a host microcontroller load a bank of eight 8-bit control registers. SCL and SDA are oversampled on a fast system clock through two-flop synchronizers. Bus conditions and clock edges are recovered from the synchronized copies. The block answers only to one fixed write address. The byte after the address picks a starting register index and a stepping mode, and each byte after that is written into the bank.

Acknowledges are given by an open-drain enable that pulls SDA low during the ninth clock of each accepted byte. The register contents are always visible on a flat parallel output. Every accepted data byte also produces a one-cycle write strobe that carries the index it was aimed at. That includes bytes that land on the unbacked indices 8 to 15, which update nothing.

Top module: `i2c_cfg_slave`

## Requirements
- R1: SDA falling while SCL is high is a START. It restarts address matching from any state, even in the middle of a byte, and a partly received byte is dropped.
- R2: The first byte after START is accepted only when it equals 0x88 (7-bit address 1000100, write bit 0). Any other value, including 0x89 with the read bit set, gets no acknowledge, and every later byte gets none until the next START.
- R3: The slave pulls SDA low only during the ninth (acknowledge) clock of an accepted address, subaddress or data byte. It leaves SDA released while the host sends data bits, and the enable never changes while SCL is high.
- R4: In the subaddress byte, bits 3:0 are the starting index and bit 4 is the stepping flag. Bits 7:5 have no effect.
- R5: With the stepping flag at 0, every data byte up to STOP or START is written to the register named by the subaddress, and the last byte is the one that stays.
- R6: With the stepping flag at 1, the index advances by one after each data byte and wraps from 15 to 0. Bytes aimed at indices 8 to 15 change no register.
- R7: After reset the registers hold 0x02 at index 0, 0x0E at index 1, 0x30 at index 2, 0x00 at indices 3 to 5, and 0x50 at indices 6 and 7. Register i appears on regsOut[8*i+7:8*i].
- R8: Each accepted data byte gives exactly one one-cycle wrStrobe pulse, and wrIndex carries the index the byte was aimed at during that pulse.
- R9: SDA rising while SCL is high is a STOP. After it, bytes clocked without a new START get no acknowledge and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw I2C clock line |
| sdaIn | input | 1 | Raw I2C data line |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |
| regsOut | output | 64 | All eight registers, index 0 in the low byte |
| wrStrobe | output | 1 | One-cycle pulse per accepted data byte |
| wrIndex | output | 4 | Target index of the byte during wrStrobe |

## Verification
A new START can arrive while the control is part-way through a data byte. Restart detection and byte assembly then compete for the same bit counter and phase state. The bench provokes this by breaking off a byte after four bits and opening a repeated START. It checks that no strobe fires for the broken byte, that the register bank is unchanged, and that the next address is matched and acknowledged again. A second overlap is the index wrap during a long stepping burst, where a write to a real register follows directly after discarded writes. The bench judges this against a model of the index and of the strobe count.

// File: rtl/i2c_cfg_pkg.sv
`timescale 1ns/1ps
package i2c_cfg_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned BANK_W   = DATA_W * NUM_REGS;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } wrCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA
  } phase_t;

  function automatic logic [DATA_W-1:0] resetValue(input int unsigned i);
    case (i)
      0:       resetValue = 8'h02;
      1:       resetValue = 8'h0E;
      2:       resetValue = 8'h30;
      6, 7:    resetValue = 8'h50;
      default: resetValue = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_cfg_sync.sv
`timescale 1ns/1ps
module i2c_cfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int k = 1; k < STAGES; k++) begin
        sclPipe[k] <= sclPipe[k-1];
        sdaPipe[k] <= sdaPipe[k-1];
      end
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/i2c_cfg_ctrl.sv
`timescale 1ns/1ps
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclS,
  input  logic   sdaS,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   startDet,
  input  logic   stopDet,
  output logic   sdaOe,
  output wrCmd_t cmd
);
  localparam logic [DATA_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  phase_t            phase;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic              ackPhase;
  logic [IDX_W-1:0]  curIdx;
  logic              autoInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      ackPhase <= 1'b0;
      curIdx   <= '0;
      autoInc  <= 1'b0;
      sdaOe    <= 1'b0;
      cmd      <= '0;
    end else begin
      cmd.wrEn <= 1'b0;
      if (startDet) begin
        phase    <= ST_ADDR;
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        sdaOe    <= 1'b0;
      end else if (stopDet) begin
        phase    <= ST_IDLE;
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        sdaOe    <= 1'b0;
      end else if (phase != ST_IDLE) begin
        if (sclRise && !ackPhase && bitCnt < CNT_W'(DATA_W)) begin
          shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
          bitCnt   <= bitCnt + 1'b1;
        end else if (sclFall) begin
          if (ackPhase) begin
            ackPhase <= 1'b0;
            sdaOe    <= 1'b0;
            bitCnt   <= '0;
          end else if (bitCnt == CNT_W'(DATA_W)) begin
            case (phase)
              ST_ADDR: begin
                if (shiftReg == ADDR_BYTE) begin
                  sdaOe    <= 1'b1;
                  ackPhase <= 1'b1;
                  phase    <= ST_SUB;
                end else begin
                  phase  <= ST_IDLE;
                  bitCnt <= '0;
                end
              end
              ST_SUB: begin
                curIdx   <= shiftReg[IDX_W-1:0];
                autoInc  <= shiftReg[IDX_W];
                sdaOe    <= 1'b1;
                ackPhase <= 1'b1;
                phase    <= ST_DATA;
              end
              ST_DATA: begin
                cmd.wrEn <= 1'b1;
                cmd.idx  <= curIdx;
                cmd.data <= shiftReg;
                if (autoInc) curIdx <= curIdx + 1'b1;
                sdaOe    <= 1'b1;
                ackPhase <= 1'b1;
              end
              default: phase <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  // R3: acknowledge enable holds still while SCL stays high
  a_r3_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS) && !$past(startDet) && !$past(stopDet)) |-> $stable(sdaOe));

  // R8: a write strobe never lasts two cycles
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn |=> !cmd.wrEn);

  // R1: a START re-arms address matching from bit zero
  a_r1_start_rearm: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (phase == ST_ADDR && bitCnt == '0 && !sdaOe));

  // R2: an idle (unaddressed) slave never drives the line
  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_IDLE && !startDet) |=> !sdaOe);

  // R9: after STOP nothing is written until a new START
  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !cmd.wrEn);
endmodule

// File: rtl/i2c_cfg_regbank.sv
`timescale 1ns/1ps
module i2c_cfg_regbank
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrCmd_t            cmd,
  output logic [BANK_W-1:0] regsOut
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= resetValue(i);
      else if (cmd.wrEn && cmd.idx == IDX_W'(i)) q <= cmd.data;
    end
    assign regsOut[i*DATA_W +: DATA_W] = q;

    // R5: a write aimed at this slot lands in it on the next cycle
    a_r5_reg_load: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.wrEn && cmd.idx == IDX_W'(i)) |=> (regsOut[i*DATA_W +: DATA_W] == $past(cmd.data)));
  end

  // R6: writes to indices without a register leave the whole bank untouched
  a_r6_upper_discard: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrEn && cmd.idx >= IDX_W'(NUM_REGS)) |=> $stable(regsOut));
endmodule

// File: rtl/i2c_cfg_slave.sv
`timescale 1ns/1ps
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h44,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [BANK_W-1:0] regsOut,
  output logic              wrStrobe,
  output logic [IDX_W-1:0]  wrIndex
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  wrCmd_t cmd;

  i2c_cfg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_cfg_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .sdaOe(sdaOe), .cmd(cmd)
  );

  i2c_cfg_regbank bank_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regsOut(regsOut)
  );

  assign wrStrobe = cmd.wrEn;
  assign wrIndex  = cmd.idx;
endmodule

// File: tb/i2c_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_cfg_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe;
  logic [63:0] regsOut;
  logic wrStrobe;
  logic [3:0] wrIndex;
  wire sdaBus = sdaDrv & ~sdaOe;

  i2c_cfg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .regsOut(regsOut), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
  );

  int checks = 0;
  int errors = 0;
  int strobeCnt = 0;
  logic [3:0] lastIdx = 4'h0;
  logic [7:0] expRegs [8];
  logic [7:0] dq [16];
  bit finished = 0;

  always @(posedge clk) begin
    if (wrStrobe) begin
      strobeCnt <= strobeCnt + 1;
      lastIdx   <= wrIndex;
    end
  end

  function automatic logic [7:0] resetExp(input int i);
    case (i)
      0: return 8'h02;
      1: return 8'h0E;
      2: return 8'h30;
      6, 7: return 8'h50;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < 8; i++)
      check(regsOut[i*8 +: 8] == expRegs[i], req, $sformatf("register %0d", i),
            int'(regsOut[i*8 +: 8]), int'(expRegs[i]));
  endtask

  task automatic i2cStart();
    sdaDrv = 1'b1; waitq(1);
    sclDrv = 1'b1; waitq(1);
    sdaDrv = 1'b0; waitq(1);
    sclDrv = 1'b0; waitq(1);
  endtask

  task automatic i2cStop();
    sdaDrv = 1'b0; waitq(1);
    sclDrv = 1'b1; waitq(1);
    sdaDrv = 1'b1; waitq(2);
  endtask

  // R3: while the host drives a data bit the line must follow the host
  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      sdaDrv = b[i]; waitq(1);
      sclDrv = 1'b1; waitq(1);
      check(sdaBus == b[i], "R3", "line during data bit", int'(sdaBus), int'(b[i]));
      waitq(1);
      sclDrv = 1'b0; waitq(1);
    end
  endtask

  task automatic ackClock(output bit acked);
    sdaDrv = 1'b1; waitq(1);
    sclDrv = 1'b1; waitq(1);
    acked = ~sdaBus;
    waitq(1);
    sclDrv = 1'b0; waitq(1);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    ackClock(acked);
  endtask

  task automatic doXfer(input logic [7:0] addr, input logic [7:0] sub, input int n, input bit withStop);
    int s0;
    int expStrobes;
    logic [3:0] idx;
    logic [3:0] lastExp;
    bit ok;
    bit a;
    string tag;
    s0 = strobeCnt;
    expStrobes = 0;
    lastExp = 4'h0;
    ok = (addr == 8'h88);
    idx = sub[3:0];
    tag = sub[4] ? "R6" : "R5";
    i2cStart();
    sendByte(addr, a);
    check(a == ok, "R2", "address acknowledge", int'(a), int'(ok));
    sendByte(sub, a);
    check(a == ok, "R4", "subaddress acknowledge", int'(a), int'(ok));
    for (int k = 0; k < n; k++) begin
      sendByte(dq[k], a);
      check(a == ok, ok ? "R3" : "R2", "data acknowledge", int'(a), int'(ok));
      if (ok) begin
        if (idx < 4'd8) expRegs[idx] = dq[k];
        expStrobes++;
        lastExp = idx;
        if (sub[4]) idx = idx + 4'd1;
      end
    end
    if (withStop) i2cStop();
    waitq(1);
    check(strobeCnt - s0 == expStrobes, "R8", "strobe count", strobeCnt - s0, expStrobes);
    if (expStrobes > 0)
      check(lastIdx == lastExp, "R8", "last strobe index", int'(lastIdx), int'(lastExp));
    checkRegs(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all requirements actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    int s0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) expRegs[i] = resetExp(i);
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R7: reset values and released line
    checkRegs("R7");
    check(sdaOe == 1'b0, "R7", "line released after reset", int'(sdaOe), 0);

    // R5 / R4: fixed index with upper subaddress bits set
    dq[0] = 8'h11; dq[1] = 8'h22; dq[2] = 8'h3C;
    doXfer(8'h88, 8'hE2, 3, 1'b1);

    // R6: stepping burst from 6 through the discarded slots and wrap to 1
    for (int k = 0; k < 12; k++) dq[k] = 8'hA0 + 8'(k);
    doXfer(8'h88, 8'h16, 12, 1'b1);

    // R2: wrong address and read bit
    dq[0] = 8'h55; dq[1] = 8'h66;
    doXfer(8'h8A, 8'h00, 2, 1'b1);
    doXfer(8'h89, 8'h01, 2, 1'b1);

    // R1: START in the middle of a data byte
    dq[0] = 8'h77;
    doXfer(8'h88, 8'h13, 1, 1'b0);
    s0 = strobeCnt;
    sendBits(8'hF0, 4);
    i2cStart();
    waitq(1);
    check(strobeCnt == s0, "R1", "no strobe for broken byte", strobeCnt - s0, 0);
    checkRegs("R1");
    sendByte(8'h88, a);
    check(a == 1'b1, "R1", "address matched after restart", int'(a), 1);
    sendByte(8'h05, a);
    sendByte(8'h9E, a);
    expRegs[5] = 8'h9E;
    i2cStop();
    waitq(1);
    checkRegs("R1");

    // R9: bytes after STOP without START
    sclDrv = 1'b0; waitq(1);
    s0 = strobeCnt;
    sendByte(8'h88, a);
    check(a == 1'b0, "R9", "no ack without START", int'(a), 0);
    sendByte(8'h00, a);
    sendByte(8'hFF, a);
    check(a == 1'b0, "R9", "no ack for data without START", int'(a), 0);
    sdaDrv = 1'b1; waitq(1);
    sclDrv = 1'b1; waitq(2);
    check(strobeCnt == s0, "R9", "no strobe without START", strobeCnt - s0, 0);
    checkRegs("R9");

    // random traffic
    for (int t = 0; t < 25; t++) begin
      logic [7:0] ad;
      logic [7:0] sb;
      int n;
      ad = ($urandom % 5 == 0) ? 8'($urandom) : 8'h88;
      sb = 8'($urandom);
      n = 1 + int'($urandom % 10);
      for (int k = 0; k < n; k++) dq[k] = 8'($urandom);
      doXfer(ad, sb, n, 1'b1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule